// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a synchronous memory device. A 16-state controller is stepped by the test clock and the mode-select input. It moves a 3-bit instruction into the instruction register and then shifts one of three data paths between the serial input and the serial output. The three paths are a 1-bit pass-through register, a 32-bit identification word and a boundary-scan register. The boundary-scan register loads the parallel values of the memory's pin ring.

The instruction set is deliberately not standard. Two instructions sample the pin ring and tri-state the memory's data drivers while they are in force. One instruction samples the pin ring without disturbing the memory, and it never applies the data shifted into it. Three codes are unassigned and behave as the pass-through. The block drives a force-high-Z control for the data drivers. It also drives the serial output value together with an enable, and a pad cell outside the block uses that enable to tri-state the pin.

Top module: `sram_tap`

## Requirements
- R1: An active-low `trst_n` forces the controller into Test-Logic-Reset at once. In that state the instruction becomes IDCODE (001), `hiz_force` is 0 and `tdo_en` is 0.
- R2: Five rising test-clock edges with `tms` high bring the controller to Test-Logic-Reset from any state. Once there, `hiz_force` falls and IDCODE is the current instruction again.
- R3: In Capture-IR the instruction shift stage loads 001. The bits come out on `tdo_data` least significant bit first, so the order is 1, 0, 0.
- R4: Under IDCODE a data scan returns the 32-bit identity word, least significant bit first. Bit 0 is 1, bits 11:1 are 00000110100, and bits 31:12 hold the revision, depth, width and part fields set by parameters, in that bit order from the top.
- R5: Under BYPASS (111) the data path is a single register that captures 0. A bit on `tdi` appears on `tdo_data` one clock later.
- R6: The codes 011, 101 and 110 act exactly as BYPASS and never assert `hiz_force`.
- R7: EXTEST (000) captures `io_ring` into the boundary-scan register and selects it. Bit 0 of `io_ring` is shifted out first. While EXTEST is current, `hiz_force` is 1.
- R8: SAMPLE-Z (010) captures and selects the boundary-scan register the same way, and `hiz_force` is 1 while it is current.
- R9: SAMPLE/PRELOAD (100) captures and selects the boundary-scan register with `hiz_force` at 0. The data shifted in has no effect: `hiz_force` stays 0, and the next capture returns the live `io_ring` and not the shifted data.
- R10: A newly shifted instruction takes effect only on the falling edge in Update-IR. Until then, `hiz_force` keeps the value set by the previous instruction, also through Exit1-IR.
- R11: `tdo_en` is 1 only while the controller is in Shift-DR or Shift-IR.
- R12: `tdo_data` changes only on falling test-clock edges, and it keeps its value across rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| io_ring | input | BSR_LEN | Parallel pin-ring values that the boundary-scan register captures |
| tdo_data | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for the serial-out pad |
| hiz_force | output | 1 | Forces the memory data drivers to high-Z |

## Verification
The assertions take for granted that `tms` and `tdi` are settled before each rising edge. They also take for granted that `io_ring` is steady in the cycle of Capture-DR, and that `trst_n` is released clear of a rising edge. The stimulus changes `tms`, `tdi` and `io_ring` only one time unit after a falling edge, which is half a period away from the next capture edge. Reset is released the same way. The bench then holds `tms` high while the release synchronizer settles, so the controller leaves Test-Logic-Reset only on a deliberate low.

// File: rtl/sram_tap_pkg.sv
package sram_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET  = 4'h0,
    ST_IDLE   = 4'h1,
    ST_SEL_DR = 4'h2,
    ST_CAP_DR = 4'h3,
    ST_SHF_DR = 4'h4,
    ST_EX1_DR = 4'h5,
    ST_PAU_DR = 4'h6,
    ST_EX2_DR = 4'h7,
    ST_UPD_DR = 4'h8,
    ST_SEL_IR = 4'h9,
    ST_CAP_IR = 4'hA,
    ST_SHF_IR = 4'hB,
    ST_EX1_IR = 4'hC,
    ST_PAU_IR = 4'hD,
    ST_EX2_IR = 4'hE,
    ST_UPD_IR = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/sram_tap_fsm.sv
module sram_tap_fsm
  import sram_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R2
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == ST_RESET && tms) |=> (state_q == ST_RESET));

  // R2
  sel_ir_exit_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == ST_SEL_IR && tms) |=> (state_q == ST_RESET));

endmodule

// File: rtl/sram_tap_ir.sv
module sram_tap_ir
  import sram_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output dr_path_e   path,
  output logic       hiz_force
);

  logic [IR_W-1:0] ir_sh_q, ir_sh_d;
  logic            ir_sh_en;
  logic [IR_W-1:0] instr_q, instr_d;
  logic            instr_en;

  // shift stage, rising edge
  always_comb begin
    ir_sh_en = (state == ST_CAP_IR) || (state == ST_SHF_IR);
    ir_sh_d  = ir_sh_q;
    if (state == ST_CAP_IR)      ir_sh_d = IR_CAPTURE;
    else if (state == ST_SHF_IR) ir_sh_d = {tdi, ir_sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        ir_sh_q <= IR_CAPTURE;
    else if (ir_sh_en) ir_sh_q <= ir_sh_d;
  end

  // current instruction, falling edge
  always_comb begin
    instr_en = (state == ST_UPD_IR) || (state == ST_RESET);
    instr_d  = (state == ST_RESET) ? OP_IDCODE : ir_sh_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)        instr_q <= OP_IDCODE;
    else if (instr_en) instr_q <= instr_d;
  end

  always_comb begin
    path      = PATH_BYP;
    hiz_force = 1'b0;
    case (instr_q)
      OP_EXTEST:  begin path = PATH_BSR; hiz_force = 1'b1; end
      OP_SAMPLEZ: begin path = PATH_BSR; hiz_force = 1'b1; end
      OP_SAMPLE:  path = PATH_BSR;
      OP_IDCODE:  path = PATH_ID;
      default:    path = PATH_BYP;
    endcase
  end

  assign ir_lsb = ir_sh_q[0];

  // R1
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |-> (instr_q == OP_IDCODE));

  // R10
  instr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |-> $stable(instr_q));

  // R7
  hiz_path_chk: assert property (@(posedge tck) disable iff (!rst_n)
    hiz_force |-> (path == PATH_BSR));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sh_q == IR_CAPTURE));

endmodule

// File: rtl/sram_tap_dr.sv
module sram_tap_dr
  import sram_tap_pkg::*;
#(
  parameter int          BSR_LEN = 53,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  dr_path_e           path,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] io_ring,
  output logic               dr_lsb
);

  logic [BSR_LEN-1:0] bsr_q, bsr_d;
  logic [31:0]        id_q, id_d;
  logic               byp_q, byp_d;
  logic               cap, shf;
  logic               bsr_en, id_en, byp_en;

  always_comb begin
    cap    = (state == ST_CAP_DR);
    shf    = (state == ST_SHF_DR);
    bsr_en = (path == PATH_BSR) && (cap || shf);
    id_en  = (path == PATH_ID)  && (cap || shf);
    byp_en = (path == PATH_BYP) && (cap || shf);
    bsr_d  = cap ? io_ring : {tdi, bsr_q[BSR_LEN-1:1]};
    id_d   = cap ? ID_WORD : {tdi, id_q[31:1]};
    byp_d  = cap ? 1'b0    : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_q <= '0;
    else if (bsr_en) bsr_q <= bsr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_WORD;
    else if (id_en) id_q <= id_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_comb begin
    case (path)
      PATH_BSR: dr_lsb = bsr_q[0];
      PATH_ID:  dr_lsb = id_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end

  // R4
  id_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_ID) |=> (id_q == ID_WORD));

  // R5
  byp_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_BYP) |=> (byp_q == 1'b0));

  // R7
  bsr_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_BSR) |=> (bsr_q == $past(io_ring)));

endmodule

// File: rtl/sram_tap.sv
module sram_tap
  import sram_tap_pkg::*;
#(
  parameter int          BSR_LEN    = 53,
  parameter logic [3:0]  ID_REV     = 4'h1,
  parameter logic [4:0]  ID_DEPTH   = 5'h0A,
  parameter logic [4:0]  ID_WIDTH   = 5'h03,
  parameter logic [5:0]  ID_PART    = 6'h2B
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] io_ring,
  output logic               tdo_data,
  output logic               tdo_en,
  output logic               hiz_force
);

  localparam logic [10:0] MAKER_CODE = 11'b00000110100;
  localparam logic [31:0] ID_WORD    =
    {ID_REV, ID_DEPTH, ID_WIDTH, ID_PART, MAKER_CODE, 1'b1};

  logic [1:0] rst_sync_q;
  logic       rst_n;
  tap_state_e state;
  dr_path_e   path;
  logic       ir_lsb, dr_lsb;
  logic       tdo_d, en_d;
  logic       tdo_q, en_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sram_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  sram_tap_ir u_ir (
    .tck       (tck),
    .rst_n     (rst_n),
    .state     (state),
    .tdi       (tdi),
    .ir_lsb    (ir_lsb),
    .path      (path),
    .hiz_force (hiz_force)
  );

  sram_tap_dr #(
    .BSR_LEN (BSR_LEN),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .path    (path),
    .tdi     (tdi),
    .io_ring (io_ring),
    .dr_lsb  (dr_lsb)
  );

  always_comb begin
    en_d  = (state == ST_SHF_IR) || (state == ST_SHF_DR);
    tdo_d = (state == ST_SHF_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en_d;
      if (en_d) tdo_q <= tdo_d;
    end
  end

  assign tdo_data = tdo_q;
  assign tdo_en   = en_q;

  // R11
  tdo_en_state_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  // R1
  reset_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |-> (!hiz_force && !tdo_en));

endmodule

// File: tb/sram_tap_tb_top.sv
`timescale 1ns/1ps
module sram_tap_tb_top;

  localparam int          BSR_LEN = 53;
  localparam logic [31:0] EXP_ID  =
    {4'h1, 5'h0A, 5'h03, 6'h2B, 11'b00000110100, 1'b1};

  logic               tck = 1'b0;
  logic               trst_n = 1'b0;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [BSR_LEN-1:0] io_ring = '0;
  logic               tdo_data, tdo_en, hiz_force;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [127:0] sout;

  always #2 tck = ~tck;

  sram_tap dut_i (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdi       (tdi),
    .io_ring   (io_ring),
    .tdo_data  (tdo_data),
    .tdo_en    (tdo_en),
    .hiz_force (hiz_force)
  );

  always @(posedge tck) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive inputs, cross one rising edge, stop just after the falling edge
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(negedge tck);
    #1;
  endtask

  task automatic go_reset();
    tms = 1'b1;
    trst_n = 1'b0;
    @(negedge tck); #1;
    chk("R1 hiz in reset", hiz_force, 1'b0);
    chk("R1 tdo_en in reset", tdo_en, 1'b0);
    trst_n = 1'b1;
    repeat (4) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic dr_scan(input int n, input logic [127:0] din);
    sout = '0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R11 tdo_en in Shift-DR", tdo_en, 1'b1);
    for (int i = 0; i < n; i++) begin
      sout[i] = tdo_data;
      step(i == n - 1, din[i]);
    end
    chk("R11 tdo_en after Shift-DR", tdo_en, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic ir_scan(input logic [2:0] code, input logic hiz_before);
    sout = '0;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R11 tdo_en in Shift-IR", tdo_en, 1'b1);
    for (int i = 0; i < 3; i++) begin
      sout[i] = tdo_data;
      step(i == 2, code[i]);
    end
    chk("R10 hiz held before Update-IR", hiz_force, hiz_before);
    chk("R3 capture pattern", sout[2:0], 3'b001);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    go_reset();
    chk("R1 hiz after reset", hiz_force, 1'b0);
    chk("R11 tdo_en idle", tdo_en, 1'b0);
  endtask

  task automatic t_idcode();
    dr_scan(32, '0);
    chk("R4 identity word", sout[31:0], EXP_ID);
    chk("R4 presence bit", sout[0], 1'b1);
  endtask

  task automatic t_bypass();
    logic [7:0] pat;
    logic v;
    pat = 8'b1011_0011;
    ir_scan(3'b111, 1'b0);
    chk("R5 hiz under bypass", hiz_force, 1'b0);
    dr_scan(9, {120'd0, 1'b0, pat});
    chk("R5 one-cycle path", sout[8:0], {pat, 1'b0});
    // R12: output moves only at the falling edge
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    v = tdo_data;
    tdi = 1'b1;
    @(posedge tck); #1;
    chk("R12 stable over rising edge", tdo_data, v);
    @(negedge tck); #1;
    chk("R12 update at falling edge", tdo_data, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic t_reserved();
    logic [2:0] codes [3];
    codes[0] = 3'b011; codes[1] = 3'b101; codes[2] = 3'b110;
    for (int k = 0; k < 3; k++) begin
      ir_scan(codes[k], 1'b0);
      chk("R6 reserved no hiz", hiz_force, 1'b0);
      dr_scan(5, 128'b1101);
      chk("R6 reserved acts as bypass", sout[4:0], 5'b11010);
    end
  endtask

  task automatic t_extest();
    io_ring = 53'h0A_5C3F_0E96_D247;
    ir_scan(3'b000, 1'b0);
    chk("R7 hiz under EXTEST", hiz_force, 1'b1);
    dr_scan(BSR_LEN, '0);
    chk("R7 ring captured", sout[BSR_LEN-1:0], io_ring);
    ir_scan(3'b001, 1'b1);
    chk("R10 hiz released after update", hiz_force, 1'b0);
  endtask

  task automatic t_samplez();
    io_ring = 53'h15_A3C0_F169_2DB8;
    ir_scan(3'b010, 1'b0);
    chk("R8 hiz under SAMPLE-Z", hiz_force, 1'b1);
    dr_scan(BSR_LEN, {128{1'b1}});
    chk("R8 ring captured", sout[BSR_LEN-1:0], io_ring);
    ir_scan(3'b100, 1'b1);
    chk("R9 hiz released", hiz_force, 1'b0);
  endtask

  task automatic t_preload();
    logic [BSR_LEN-1:0] first;
    first = 53'h1F_0123_4567_89AB;
    io_ring = first;
    dr_scan(BSR_LEN, {75'd0, ~first});
    chk("R9 ring captured", sout[BSR_LEN-1:0], first);
    chk("R9 hiz after shift", hiz_force, 1'b0);
    io_ring = 53'h00_FEDC_BA98_7654;
    dr_scan(BSR_LEN, '0);
    chk("R9 live ring not shifted data", sout[BSR_LEN-1:0], 53'h00_FEDC_BA98_7654);
  endtask

  task automatic t_tms_reset();
    ir_scan(3'b000, 1'b0);
    chk("R7 hiz before tms reset", hiz_force, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b0);
    chk("R2 hiz after five tms high", hiz_force, 1'b0);
    chk("R2 tdo_en after five tms high", tdo_en, 1'b0);
    step(1'b0, 1'b0);
    dr_scan(32, '0);
    chk("R2 IDCODE restored", sout[31:0], EXP_ID);
  endtask

  task automatic t_trst();
    ir_scan(3'b010, 1'b0);
    chk("R8 hiz before trst", hiz_force, 1'b1);
    #0.5;
    trst_n = 1'b0;
    #0.5;
    chk("R1 async reset drops hiz", hiz_force, 1'b0);
    go_reset();
    dr_scan(32, '0);
    chk("R1 IDCODE after trst", sout[31:0], EXP_ID);
  endtask

  initial begin
    t_reset();
    t_idcode();
    t_bypass();
    t_reserved();
    t_extest();
    t_samplez();
    t_preload();
    t_tms_reset();
    t_trst();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule